// File: doc/BRIEF.md
# Reconfigurable State-Metric Ring Router

This block routes boundary state metrics between the processing cores of one turbo component decoder. Each core decodes a sub-block of the frame. At the end of a sub-block it hands its boundary metrics to the core that decodes the next sub-block. The cores that take part are a contiguous run of physical positions, taken modulo the core count. The run begins at a programmable start position and holds a programmable number of cores. The last core in the run feeds the first one, which closes the ring.

The router is reconfigured at runtime by a strobe that carries a start position and an active count. A new setting is taken only when the ring carries no traffic and the count is legal. When a setting is taken, the routing is rebuilt so that data moves only among the selected cores, in logical order. Cores outside the run see an idle input, and their outputs are never routed. Every routed vector passes through one register stage.

Top module: `sm_ring_router`

## Requirements
- R1: After reset, every out_valid bit is 0 and out_metrics is all zero. The configuration is start 0 with count 4, so every core takes part.
- R2: Transfer latency is exactly one clock. A vector presented in cycle t appears at the destination after the rising edge that ends cycle t. Before that edge the outputs still show the previous result.
- R3: Logical position k (0 ≤ k < count) is physical core (start + k) mod 4. Its input vector (in_valid[p] and in_metrics slice p) is delivered to the physical core at logical position (k + 1) mod count.
- R4: With count 1, the single active core receives its own vector.
- R5: With count 2, the two active cores exchange vectors.
- R6: The run wraps modulo 4. For example, start 2 with count 3 uses cores 2, 3 and 0, and routes 2→3, 3→0 and 0→2.
- R7: An inactive core receives out_valid 0 and zero metrics. Whatever an inactive core drives on its input does not reach any output.
- R8: A load with cfg_count of 0, or greater than 4, is rejected and the previous configuration is kept. cfg_count is 3 bits wide and unsigned.
- R9: A configuration is taken only on a cycle where cfg_load is 1 and every in_valid bit is 0. A load made while any in_valid bit is 1 has no effect.
- R10: out_valid[d] equals the in_valid bit of d's source core. When out_valid[d] is 0, slice d of out_metrics is zero.
- R11: Core c occupies bits [88c+87 : 88c] of in_metrics and out_metrics. Within that slice, metric m occupies bits [11m+10 : 11m].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Reconfigure strobe |
| cfg_start | input | 2 | Physical index of logical position 0 |
| cfg_count | input | 3 | Number of active cores, 1 to 4 |
| in_valid | input | 4 | Per-core outgoing vector valid |
| in_metrics | input | 352 | Per-core outgoing metric vectors, 8 × 11 bits each |
| out_valid | output | 4 | Per-core incoming vector valid |
| out_metrics | output | 352 | Per-core incoming metric vectors |

## Verification
The assertions assume that the bench never raises in_valid while reset is held. Under that assumption the first sample after reset looks back at an empty ring. The assertions also assume that a configuration change can only appear together with an idle ring and a legal count.

The bench sweeps every start and every legal count. For each setting it applies all 16 valid patterns, each with fresh metric data computed from the core, metric and pattern indices. Reconfiguration always happens with in_valid held low, except for the deliberate busy-load and illegal-count probes. After each probe a traffic pattern shows whether the previous routing survived.

// File: rtl/sm_ring_pkg.sv
package sm_ring_pkg;
  localparam int unsigned NCORE_DEF = 4;
  localparam int unsigned NSM_DEF   = 8;
  localparam int unsigned SMW_DEF   = 11;
endpackage

// File: rtl/sm_ring_cfg.sv
module sm_ring_cfg #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned IW    = 2,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic          ring_busy,
  input  logic [IW-1:0] start_in,
  input  logic [CW-1:0] count_in,
  output logic [IW-1:0] start_q,
  output logic [CW-1:0] count_q
);
  logic          accept;
  logic [IW-1:0] start_d;
  logic [CW-1:0] count_d;

  always_comb begin
    accept = load_req && !ring_busy &&
             (count_in != '0) && (int'(count_in) <= int'(NCORE)) &&
             (int'(start_in) < int'(NCORE));
    start_d = accept ? start_in : start_q;
    count_d = accept ? count_in : count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= CW'(NCORE);
    end else begin
      start_q <= start_d;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/sm_ring_map.sv
module sm_ring_map #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned IW    = 2,
  parameter int unsigned CW    = 3
) (
  input  logic [IW-1:0]             start,
  input  logic [CW-1:0]             count,
  output logic [NCORE-1:0][IW-1:0]  src_sel,
  output logic [NCORE-1:0]          dst_act
);
  always_comb begin
    for (int d = 0; d < int'(NCORE); d++) begin
      int rel;
      int srcl;
      rel  = (d + int'(NCORE) - int'(start)) % int'(NCORE);
      srcl = (rel == 0) ? (int'(count) - 1) : (rel - 1);
      dst_act[d] = (rel < int'(count));
      src_sel[d] = IW'((int'(start) + srcl) % int'(NCORE));
    end
  end
endmodule

// File: rtl/sm_ring_stage.sv
module sm_ring_stage #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned VW    = 88,
  parameter int unsigned IW    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCORE-1:0]          in_valid,
  input  logic [NCORE*VW-1:0]       in_data,
  input  logic [NCORE-1:0][IW-1:0]  src_sel,
  input  logic [NCORE-1:0]          dst_act,
  output logic [NCORE-1:0]          out_valid,
  output logic [NCORE*VW-1:0]       out_data
);
  for (genvar d = 0; d < NCORE; d++) begin : g_lane
    logic          v_d;
    logic [VW-1:0] w_d;

    always_comb begin
      v_d = dst_act[d] && in_valid[src_sel[d]];
      w_d = v_d ? in_data[src_sel[d]*VW +: VW] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid[d]           <= 1'b0;
        out_data[d*VW +: VW]   <= '0;
      end else begin
        out_valid[d]           <= v_d;
        out_data[d*VW +: VW]   <= w_d;
      end
    end
  end
endmodule

// File: rtl/sm_ring_router.sv
module sm_ring_router
  import sm_ring_pkg::*;
#(
  parameter int unsigned NCORE = NCORE_DEF,
  parameter int unsigned NSM   = NSM_DEF,
  parameter int unsigned SMW   = SMW_DEF,
  localparam int unsigned IW   = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int unsigned CW   = $clog2(NCORE + 1),
  localparam int unsigned VW   = NSM * SMW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_load,
  input  logic [IW-1:0]         cfg_start,
  input  logic [CW-1:0]         cfg_count,
  input  logic [NCORE-1:0]      in_valid,
  input  logic [NCORE*VW-1:0]   in_metrics,
  output logic [NCORE-1:0]      out_valid,
  output logic [NCORE*VW-1:0]   out_metrics
);
  logic [1:0]               rst_pipe;
  logic                     rst_sync_n;
  logic [IW-1:0]            act_start;
  logic [CW-1:0]            act_count;
  logic [NCORE-1:0][IW-1:0] src_sel;
  logic [NCORE-1:0]         dst_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sm_ring_cfg #(.NCORE(NCORE), .IW(IW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .load_req(cfg_load), .ring_busy(|in_valid),
    .start_in(cfg_start), .count_in(cfg_count),
    .start_q(act_start), .count_q(act_count)
  );

  sm_ring_map #(.NCORE(NCORE), .IW(IW), .CW(CW)) u_map (
    .start(act_start), .count(act_count),
    .src_sel(src_sel), .dst_act(dst_act)
  );

  sm_ring_stage #(.NCORE(NCORE), .VW(VW), .IW(IW)) u_stage (
    .clk(clk), .rst_n(rst_sync_n),
    .in_valid(in_valid), .in_data(in_metrics),
    .src_sel(src_sel), .dst_act(dst_act),
    .out_valid(out_valid), .out_data(out_metrics)
  );
endmodule

// File: rtl/sm_ring_checker.sv
module sm_ring_checker #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned VW    = 88,
  parameter int unsigned IW    = 2,
  parameter int unsigned CW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_load,
  input logic [CW-1:0]       cfg_count,
  input logic [NCORE-1:0]    in_valid,
  input logic [NCORE-1:0]    out_valid,
  input logic [NCORE*VW-1:0] out_metrics,
  input logic [IW-1:0]       act_start,
  input logic [CW-1:0]       act_count
);
  a_r2_valid_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != '0) |-> $past(in_valid != '0));

  a_r3_no_duplication: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) <= $past($countones(in_valid)));

  a_r8_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (act_count != '0) && (int'(act_count) <= int'(NCORE)));

  a_r8_reject_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && ((cfg_count == '0) || (int'(cfg_count) > int'(NCORE))))
    |=> ($stable(act_count) && $stable(act_start)));

  a_r9_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load || (in_valid != '0)) |=> ($stable(act_count) && $stable(act_start)));

  a_r4_self_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (act_count == CW'(1)) && !cfg_load
    |=> (out_valid == (NCORE'($past(in_valid[act_start])) << $past(act_start))));

  for (genvar d = 0; d < NCORE; d++) begin : g_quiet
    a_r10_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[d] |-> (out_metrics[d*VW +: VW] == '0));
  end
endmodule

bind sm_ring_router sm_ring_checker #(
  .NCORE(NCORE), .VW(VW), .IW(IW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg_load(cfg_load), .cfg_count(cfg_count),
  .in_valid(in_valid), .out_valid(out_valid), .out_metrics(out_metrics),
  .act_start(act_start), .act_count(act_count)
);

// File: tb/sm_ring_router_test.sv
`timescale 1ns/1ps
module sm_ring_router_test;
  localparam int NC = 4;
  localparam int VW = 88;
  localparam int TW = NC * VW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [1:0]    cfg_start = '0;
  logic [2:0]    cfg_count = '0;
  logic [NC-1:0] in_valid = '0;
  logic [TW-1:0] in_metrics = '0;
  logic [NC-1:0] out_valid;
  logic [TW-1:0] out_metrics;

  int checks = 0;
  int errors = 0;
  int cur_start = 0;
  int cur_cnt = 4;
  logic [NC-1:0] prev_v = '0;
  logic [TW-1:0] prev_d = '0;

  always #2.5 clk = ~clk;

  sm_ring_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_start(cfg_start),
    .cfg_count(cfg_count), .in_valid(in_valid), .in_metrics(in_metrics),
    .out_valid(out_valid), .out_metrics(out_metrics)
  );

  function automatic logic [TW-1:0] mk(int seed);
    logic [TW-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int m = 0; m < 8; m++)
        r[c*VW + m*11 +: 11] = 11'((c*97 + m*13 + seed*5 + 3) & 'h7FF);
    return r;
  endfunction

  task automatic cmp(string req, logic [NC-1:0] ev, logic [TW-1:0] ed);
    for (int d = 0; d < NC; d++) begin
      checks++;
      if (out_valid[d] !== ev[d] || out_metrics[d*VW +: VW] !== ed[d*VW +: VW]) begin
        errors++;
        $display("FAIL %s core %0d: got v=%b d=%h, expected v=%b d=%h", req, d,
                 out_valid[d], out_metrics[d*VW +: VW], ev[d], ed[d*VW +: VW]);
      end
    end
  endtask

  task automatic apply_cfg(int s, int c);
    @(negedge clk);
    cfg_load = 1'b1; cfg_start = 2'(s); cfg_count = 3'(c);
    in_valid = '0; in_metrics = '0;
    @(negedge clk);
    cfg_load = 1'b0;
    @(negedge clk);
    if (c >= 1 && c <= 4) begin cur_start = s; cur_cnt = c; end
    prev_v = '0; prev_d = '0;
  endtask

  task automatic run_pat(string req, logic [NC-1:0] v, int seed, bit ld, int ls, int lc);
    logic [TW-1:0] dat;
    logic [NC-1:0] ev;
    logic [TW-1:0] ed;
    dat = mk(seed);
    @(negedge clk);
    in_valid = v; in_metrics = dat;
    cfg_load = ld; cfg_start = 2'(ls); cfg_count = 3'(lc);
    #1 cmp("R2", prev_v, prev_d);
    ev = '0; ed = '0;
    for (int k = 0; k < cur_cnt; k++) begin
      int p, dst;
      p   = (cur_start + k) % NC;
      dst = (cur_start + ((k + 1) % cur_cnt)) % NC;
      if (v[p]) begin ev[dst] = 1'b1; ed[dst*VW +: VW] = dat[p*VW +: VW]; end
    end
    @(posedge clk); #1;
    cmp(req, ev, ed);
    cfg_load = 1'b0;
    prev_v = ev; prev_d = ed;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 cmp("R1", '0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1", '0, '0);
    // R1 default ring: start 0, count 4
    run_pat("R1", 4'hF, 1, 0, 0, 0);
    // R3 R4 R5 R6 R7 R10 R11: sweep every configuration and valid pattern
    for (int s = 0; s < 4; s++)
      for (int c = 1; c <= 4; c++) begin
        apply_cfg(s, c);
        for (int v = 0; v < 16; v++)
          run_pat(c == 1 ? "R4" : c == 2 ? "R5" : (s + c > 4) ? "R6" : "R3",
                  4'(v), s*64 + c*16 + v, 0, 0, 0);
      end
    // R7 inactive cores: start 2 count 2, only inactive cores valid
    apply_cfg(2, 2);
    run_pat("R7", 4'b0011, 900, 0, 0, 0);
    // R8 rejected counts keep previous routing
    apply_cfg(1, 3);
    apply_cfg(3, 0);
    run_pat("R8", 4'hF, 901, 0, 0, 0);
    apply_cfg(0, 5);
    run_pat("R8", 4'hF, 902, 0, 0, 0);
    apply_cfg(2, 7);
    run_pat("R8", 4'b1011, 903, 0, 0, 0);
    // R9 load while busy is ignored
    run_pat("R9", 4'b0110, 904, 1, 0, 1);
    run_pat("R9", 4'hF, 905, 0, 0, 0);
    // R9 load while idle is taken
    apply_cfg(0, 1);
    run_pat("R9", 4'hF, 906, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule